// File: doc/BRIEF.md
# SCL Low-Period Timeout Detector

This block watches the clock line of a two-wire serial bus and raises a timeout when that line is held low for one unbroken period longer than a programmed limit. All time is measured on a separate slow timing clock of about 32 kHz. The measurement therefore does not depend on the frequency of the main system clock. The clock-line level is taken from the main domain and passed through a two-flop synchronizer into the slow domain. The enable bit goes through its own two-flop synchronizer on the same path. A slow-domain state machine then measures the length of each low period.

When a period runs past the limit, the slow-domain state machine flips a toggle. The toggle crosses back into the main clock domain and becomes a single-cycle event there. That event does two things: it sets a sticky timeout flag, which software clears through `to_clr`, and it raises a one-cycle bus-reset request for the serial-bus core. A high level on the clock line restarts the measurement, so short low periods never add up to a timeout. After a timeout the detector stays quiet until the line has gone high again.

`thresh` sets the longest low period that is still allowed, counted in slow-clock samples. A value of 983 gives about 30 ms at 32.768 kHz, which lies inside the 25 to 35 ms limit of the bus specification.

The slow-domain machine has three states:
- `ST_IDLE`: the line is high or the detector is off.
- `ST_COUNT`: a low period is being timed.
- `ST_EXPIRED`: a timeout has been reported and the machine waits for the line to go high.

Its transitions are:
- IDLE→COUNT when the detector is enabled and a low sample is seen.
- COUNT→IDLE when a high sample is seen or the enable drops.
- COUNT→EXPIRED when a low sample arrives with the count already at `thresh`.
- EXPIRED→IDLE when a high sample is seen or the enable drops.

The main-domain flag machine has two states:
- `FL_CLEAR`→`FL_SET` when a crossing event arrives.
- `FL_SET`→`FL_CLEAR` when `to_clr` is high and no new event arrives in the same cycle.

Top module: `sclto_detector`

## Requirements
- R1: After reset, `to_flag` and `bus_rst_req` are 0.
- R2: With the detector enabled, a timeout is reported if and only if the synchronized clock line is low for at least `thresh`+1 consecutive slow-clock samples. A period of exactly `thresh` low samples is not reported. `thresh` must be at least 1.
- R3: Any single high sample restarts the measurement. Low periods separated by a high sample never add up to a timeout.
- R4: While `lowto_en` is 0 no timeout is reported, however long the line stays low.
- R5: `to_flag` is 1 from the cycle after a timeout event until a cycle in which `to_clr` is 1. A new event in the same cycle as a clear leaves the flag set.
- R6: Each timeout raises `bus_rst_req` for exactly one main-clock cycle, in the same cycle that `to_flag` becomes set.
- R7: One unbroken low period produces at most one timeout, however long it lasts. The detector re-arms once the line has been seen high, and a later low period can time out again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main system clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| clk_slow | input | 1 | Slow timing clock, about 32 kHz |
| scl_i | input | 1 | Bus clock-line level, already synchronized to `clk` |
| lowto_en | input | 1 | Enables the low-period timeout detection |
| thresh | input | CNT_W | Longest allowed low period in slow-clock samples; change only while the detector is disabled |
| to_clr | input | 1 | Clears the sticky timeout flag |
| to_flag | output | 1 | Sticky timeout flag |
| bus_rst_req | output | 1 | One-cycle request to reset the bus interface |

## Verification
The assertions check structural properties on every cycle:
- The counter is zero in every state except `ST_COUNT`.
- A disabled detector returns to `ST_IDLE`.
- The crossing toggle stays still in `ST_EXPIRED`.
- The main-domain event lasts one cycle, and the bus-reset request never appears without the flag.
- The flag persists until it is cleared.

Some behaviours can only be shown by the bench's scenarios, because they depend on the full two-clock path and on how long a low period lasts:
- The exact boundary between `thresh` and `thresh`+1 low samples, swept over several thresholds.
- The refusal to add up separate low periods.
- Silence while the detector is disabled.
- Exactly one request per period, and re-arming after a high sample.

// File: rtl/sclto_pkg.sv
package sclto_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } lowmon_state_t;

    typedef enum logic {
        FL_CLEAR = 1'b0,
        FL_SET   = 1'b1
    } flag_state_t;

endpackage

// File: rtl/sclto_sync.sv
module sclto_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/sclto_lowmon.sv
module sclto_lowmon
    import sclto_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk_s,
    input  logic             rst_n,
    input  logic             en_s,
    input  logic             scl_s,
    input  logic [CNT_W-1:0] thresh,
    output logic             tog_o
);
    lowmon_state_t    st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             tog, tog_nxt;

    // state register
    always_ff @(posedge clk_s or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
            tog <= 1'b0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
            tog <= tog_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        tog_nxt = tog;
        unique case (st)
            ST_IDLE: begin
                if (en_s && !scl_s) begin
                    st_nxt  = ST_COUNT;
                    cnt_nxt = CNT_W'(1);
                end
            end
            ST_COUNT: begin
                if (!en_s || scl_s) begin
                    st_nxt  = ST_IDLE;
                    cnt_nxt = '0;
                end else if (cnt >= thresh) begin
                    st_nxt  = ST_EXPIRED;
                    cnt_nxt = '0;
                    tog_nxt = ~tog;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_EXPIRED: begin
                if (!en_s || scl_s) begin
                    st_nxt = ST_IDLE;
                end
            end
            default: begin
                st_nxt  = ST_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    assign tog_o = tog;

    a_r2_cnt_only_counting: assert property (@(posedge clk_s) disable iff (!rst_n)
        (st != ST_COUNT) |-> (cnt == '0));
    a_r4_disabled_idles: assert property (@(posedge clk_s) disable iff (!rst_n)
        !en_s |=> (st == ST_IDLE));
    a_r7_no_retrigger: assert property (@(posedge clk_s) disable iff (!rst_n)
        (st == ST_EXPIRED) |=> $stable(tog));
    a_r3_high_stops_count: assert property (@(posedge clk_s) disable iff (!rst_n)
        scl_s |=> (st != ST_EXPIRED || $past(st) == ST_EXPIRED));
endmodule

// File: rtl/sclto_tog2pulse.sv
module sclto_tog2pulse #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_i,
    output logic pulse_o
);
    logic tog_sync;
    logic tog_seen;

    sclto_sync #(.STAGES(STAGES)) u_tsync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (tog_i),
        .q_o   (tog_sync)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_seen <= 1'b0;
        end else begin
            tog_seen <= tog_sync;
        end
    end

    assign pulse_o = tog_sync ^ tog_seen;

    a_r6_event_single: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/sclto_detector.sv
module sclto_detector
    import sclto_pkg::*;
#(
    parameter int CNT_W     = 10,
    parameter int SYNC_STG  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_slow,
    input  logic             scl_i,
    input  logic             lowto_en,
    input  logic [CNT_W-1:0] thresh,
    input  logic             to_clr,
    output logic             to_flag,
    output logic             bus_rst_req
);
    logic        scl_s;
    logic        en_s;
    logic        tog;
    logic        evt;
    flag_state_t fst, fst_nxt;
    logic        req_q;

    sclto_sync #(.STAGES(SYNC_STG)) u_scl_sync (
        .clk   (clk_slow),
        .rst_n (rst_n),
        .d_i   (scl_i),
        .q_o   (scl_s)
    );

    sclto_sync #(.STAGES(SYNC_STG)) u_en_sync (
        .clk   (clk_slow),
        .rst_n (rst_n),
        .d_i   (lowto_en),
        .q_o   (en_s)
    );

    sclto_lowmon #(.CNT_W(CNT_W)) u_lowmon (
        .clk_s  (clk_slow),
        .rst_n  (rst_n),
        .en_s   (en_s),
        .scl_s  (scl_s),
        .thresh (thresh),
        .tog_o  (tog)
    );

    sclto_tog2pulse #(.STAGES(SYNC_STG)) u_back (
        .clk     (clk),
        .rst_n   (rst_n),
        .tog_i   (tog),
        .pulse_o (evt)
    );

    // flag state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fst   <= FL_CLEAR;
            req_q <= 1'b0;
        end else begin
            fst   <= fst_nxt;
            req_q <= evt;
        end
    end

    // flag next state
    always_comb begin
        fst_nxt = fst;
        unique case (fst)
            FL_CLEAR: if (evt) fst_nxt = FL_SET;
            FL_SET:   if (to_clr && !evt) fst_nxt = FL_CLEAR;
            default:  fst_nxt = FL_CLEAR;
        endcase
    end

    assign to_flag     = (fst == FL_SET);
    assign bus_rst_req = req_q;

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !to_clr) |=> to_flag);
    a_r6_req_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_req |-> to_flag);
    a_r6_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_req |=> !bus_rst_req);
endmodule

// File: tb/sclto_detector_tb.sv
module sclto_detector_tb;
    localparam int CNT_W = 10;

    logic             clk = 1'b0;
    logic             clk_slow = 1'b0;
    logic             rst_n = 1'b0;
    logic             scl_i = 1'b1;
    logic             lowto_en = 1'b0;
    logic [CNT_W-1:0] thresh = CNT_W'(4);
    logic             to_clr = 1'b0;
    logic             to_flag;
    logic             bus_rst_req;

    int n_vec = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;
    always #61 clk_slow = ~clk_slow;

    sclto_detector #(.CNT_W(CNT_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_slow    (clk_slow),
        .scl_i       (scl_i),
        .lowto_en    (lowto_en),
        .thresh      (thresh),
        .to_clr      (to_clr),
        .to_flag     (to_flag),
        .bus_rst_req (bus_rst_req)
    );

    always @(negedge clk) if (bus_rst_req) pulses++;

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic slow_wait(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_slow);
    endtask

    task automatic settle();
        slow_wait(6);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        to_clr = 1'b1;
        @(negedge clk);
        to_clr = 1'b0;
        @(negedge clk);
    endtask

    // one low period of exactly len slow samples
    task automatic low_period(input int len);
        @(negedge clk_slow);
        scl_i = 1'b0;
        slow_wait(len);
        scl_i = 1'b1;
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        slow_wait(3);
        @(negedge clk);
        check("R1 flag after reset", int'(to_flag), 0);
        check("R1 req after reset", int'(bus_rst_req), 0);
        rst_n = 1'b1;

        // R4: disabled, long low period
        lowto_en = 1'b0;
        slow_wait(4);
        pulses = 0;
        low_period(20);
        settle();
        check("R4 disabled pulses", pulses, 0);
        check("R4 disabled flag", int'(to_flag), 0);

        lowto_en = 1'b1;
        slow_wait(4);

        // R2/R6/R5: sweep thresholds and period lengths
        for (int t = 2; t <= 6; t++) begin
            thresh = CNT_W'(t);
            for (int l = 1; l <= t + 3; l++) begin
                int expf;
                expf = (l >= t + 1) ? 1 : 0;
                pulses = 0;
                low_period(l);
                settle();
                check($sformatf("R2 t=%0d len=%0d flag", t, l), int'(to_flag), expf);
                check($sformatf("R6 t=%0d len=%0d req cycles", t, l), pulses, expf);
                if (expf == 1) begin
                    slow_wait(3);
                    check("R5 flag held", int'(to_flag), 1);
                    do_clear();
                    check("R5 flag cleared", int'(to_flag), 0);
                end
            end
        end

        // R3: two low periods of thresh samples split by one high sample
        thresh = CNT_W'(5);
        pulses = 0;
        @(negedge clk_slow);
        scl_i = 1'b0;
        slow_wait(5);
        scl_i = 1'b1;
        slow_wait(1);
        scl_i = 1'b0;
        slow_wait(5);
        scl_i = 1'b1;
        settle();
        check("R3 no accumulation pulses", pulses, 0);
        check("R3 no accumulation flag", int'(to_flag), 0);

        // R7: very long period gives one request, then re-arms
        for (int t = 2; t <= 4; t++) begin
            thresh = CNT_W'(t);
            pulses = 0;
            low_period(3 * t + 2);
            settle();
            check("R7 single request in long low", pulses, 1);
            low_period(t + 2);
            settle();
            check("R7 re-armed second request", pulses, 2);
            check("R5 flag still set", int'(to_flag), 1);
            do_clear();
            check("R5 cleared after R7", int'(to_flag), 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule